// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block gathers seven interrupt sources of a serial peripheral into one request line. Each source pulses or holds a raw event input. An event sets a sticky bit in a status register, and software clears that bit by writing a one to it. The enable mask is never written directly. Software uses one write-only address to set mask bits and a second write-only address to clear them, and it reads the result from a read-only address.

The request output is registered. It goes high one clock after any status bit that is also enabled in the mask is set. A source that reports a level, such as a non-empty receive queue, keeps its input high. Its bit therefore comes back straight after a clear, because a set event wins over a clear that lands in the same cycle. Register access uses a plain single-cycle port: a write strobe, an address and write data, with read data returned combinationally for the presented address.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset, status reads 0x00, mask reads 0x00 and `irq_o` is low.
- R2: A high on `evt_i[i]` sets status bit i, and the bit stays set until it is cleared. Bit positions are: 1 mode fault, 2 transmit queue below watermark, 3 transmit queue full, 4 receive queue not empty. Bits 0, 5 and 6 are general sources.
- R3: A write to byte address 0x04 clears every status bit whose write-data bit is one. Status bits whose write-data bit is zero are unchanged.
- R4: If an event and a clear reach the same status bit in the same cycle, the bit is set after that edge.
- R5: A write to address 0x08 sets the mask bits whose write-data bit is one and leaves the other mask bits unchanged.
- R6: A write to address 0x0C clears the mask bits whose write-data bit is one and leaves the other mask bits unchanged.
- R7: Reading address 0x04 returns status and reading 0x10 returns the mask, both zero-extended. Reading 0x08, 0x0C or any other address returns zero.
- R8: `irq_o` equals the OR of (status AND mask) as it stood before the previous rising edge. It therefore rises one cycle after an enabled status bit is set.
- R9: Writes to address 0x10 or to any address that is not decoded change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | Raw event inputs, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the presented address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event that sets a status bit and a write-one-to-clear aimed at that same bit can land in the same cycle. The bench provokes this directly by holding a receive-not-empty event high while it writes a one to that bit at 0x04. It then reads 0x04 on the next cycle and expects the bit still set. Random stimulus also overlaps sparse events with clears, enable and disable writes to every address. The bench compares each read and each request-line value against a model built from the requirements.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK    = 8'h10;

  // Sticky bit update: the clear acts first, then the set, so the set wins.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Mask bit update from separate set and clear strobes.
  function automatic logic mask_next(input logic cur, input logic en, input logic dis);
    return (cur | en) & ~dis;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_enable,
  output logic              hit_disable,
  output logic              hit_mask
);

  always_comb begin
    hit_status  = (addr == OFS_STATUS[ADDR_W-1:0]);
    hit_enable  = (addr == OFS_ENABLE[ADDR_W-1:0]);
    hit_disable = (addr == OFS_DISABLE[ADDR_W-1:0]);
    hit_mask    = (addr == OFS_MASK[ADDR_W-1:0]);
  end

  always_comb begin
    AST_ONE_HIT: assert ($onehot0({hit_status, hit_enable, hit_disable, hit_mask})); // R7
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_vec,
  input  logic [NUM_IRQ-1:0] clr_vec,
  output logic [NUM_IRQ-1:0] status_q
);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= sticky_next(status_q[b], clr_vec[b], set_vec[b]);
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~clr_vec) != '0) |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec))); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R4

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] en_vec,
  input  logic [NUM_IRQ-1:0] dis_vec,
  output logic [NUM_IRQ-1:0] mask_q
);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[b] <= 1'b0;
      else        mask_q[b] <= mask_next(mask_q[b], en_vec[b], dis_vec[b]);
    end
  end

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_vec & ~dis_vec) != '0) |=> ((mask_q & $past(en_vec & ~dis_vec)) == $past(en_vec & ~dis_vec))); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_vec != '0) |=> ((mask_q & $past(dis_vec)) == '0)); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_vec == '0) && (dis_vec == '0)) |=> $stable(mask_q)); // R9

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NUM_IRQ = 7,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);

  localparam int PAD_W = DATA_W - NUM_IRQ;

  logic hit_status, hit_enable, hit_disable, hit_mask;
  logic [NUM_IRQ-1:0] wbits, clr_vec, en_vec, dis_vec;
  logic [NUM_IRQ-1:0] status_q, mask_q, pending;
  logic unused_wdata_hi;
  logic irq_q;

  assign wbits           = reg_wdata_i[NUM_IRQ-1:0];
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_IRQ];

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (reg_addr_i),
    .hit_status  (hit_status),
    .hit_enable  (hit_enable),
    .hit_disable (hit_disable),
    .hit_mask    (hit_mask)
  );

  // Named write events, one vector per action.
  assign clr_vec = (reg_wr_i && hit_status)  ? wbits : '0;
  assign en_vec  = (reg_wr_i && hit_enable)  ? wbits : '0;
  assign dis_vec = (reg_wr_i && hit_disable) ? wbits : '0;

  irq_status_bank #(.NUM_IRQ(NUM_IRQ)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (evt_i),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  irq_mask_bank #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_vec  (en_vec),
    .dis_vec (dis_vec),
    .mask_q  (mask_q)
  );

  assign pending = status_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    if (hit_status)    reg_rdata_o = {{PAD_W{1'b0}}, status_q};
    else if (hit_mask) reg_rdata_o = {{PAD_W{1'b0}}, mask_q};
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |=> irq_o); // R8
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> !irq_o); // R8

endmodule

// File: tb/tb_irq_ctrl_regs.sv
`timescale 1ns/1ps
module tb_irq_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  always #4 clk = ~clk;

  irq_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0] m_status, m_mask;
  logic       m_irq;

  // Model of the requirements, stated bit by bit.
  function automatic logic [6:0] f_status(input logic [6:0] st, input logic [6:0] ev,
                                          input logic wr, input logic [4:0] a, input logic [31:0] wd);
    logic [6:0] r;
    for (int i = 0; i < 7; i++) begin
      if (ev[i])                          r[i] = 1'b1;
      else if (wr && a == 5'h04 && wd[i]) r[i] = 1'b0;
      else                                r[i] = st[i];
    end
    return r;
  endfunction

  function automatic logic [6:0] f_mask(input logic [6:0] mk, input logic wr,
                                        input logic [4:0] a, input logic [31:0] wd);
    logic [6:0] r = mk;
    if (wr && a == 5'h08) r = r | wd[6:0];
    if (wr && a == 5'h0C) r = r & ~wd[6:0];
    return r;
  endfunction

  function automatic logic [31:0] f_read(input logic [4:0] a);
    if (a == 5'h04) return {25'd0, m_status};
    if (a == 5'h10) return {25'd0, m_mask};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status <= '0; m_mask <= '0; m_irq <= 1'b0;
    end else begin
      m_status <= f_status(m_status, evt_i, reg_wr_i, reg_addr_i, reg_wdata_i);
      m_mask   <= f_mask(m_mask, reg_wr_i, reg_addr_i, reg_wdata_i);
      m_irq    <= |(m_status & m_mask);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and check outputs against the model.
  task automatic cyc(input logic [6:0] ev, input logic wr, input logic [4:0] a, input logic [31:0] wd);
    @(negedge clk);
    evt_i = ev; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
    #1;
    chk("R7 read", reg_rdata_o, f_read(a));
    chk("R8 irq", {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic rd(input logic [4:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; reg_addr_i = a; reg_wdata_i = '0;
    #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h04, "R1 status", 32'h0);
    rd(5'h10, "R1 mask", 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    // R2 sticky mode fault
    cyc(7'h02, 0, 5'h00, 0);
    rd(5'h04, "R2 set", 32'h02);
    rd(5'h04, "R2 held", 32'h02);
    // R3 zero write leaves bit, one write clears
    cyc(7'h00, 1, 5'h04, 32'h7D);
    rd(5'h04, "R3 zero bit kept", 32'h02);
    cyc(7'h00, 1, 5'h04, 32'h02);
    rd(5'h04, "R3 cleared", 32'h00);

    // R5 enable set, zeros unchanged
    cyc(7'h00, 1, 5'h08, 32'h12);
    cyc(7'h00, 1, 5'h08, 32'h04);
    rd(5'h10, "R5 mask", 32'h16);
    // R6 disable
    cyc(7'h00, 1, 5'h0C, 32'h10);
    rd(5'h10, "R6 mask", 32'h06);
    // R7 write-only addresses read zero
    rd(5'h08, "R7 enable reads 0", 32'h0);
    rd(5'h0C, "R7 disable reads 0", 32'h0);
    // R9 write to mask and undecoded addresses ignored
    cyc(7'h00, 1, 5'h10, 32'h7F);
    cyc(7'h00, 1, 5'h14, 32'h7F);
    rd(5'h10, "R9 mask kept", 32'h06);
    rd(5'h04, "R9 status kept", 32'h00);

    // R8 latency: event at cycle k, status after edge k, irq after edge k+1
    @(negedge clk);
    evt_i = 7'h04; reg_wr_i = 0; reg_addr_i = 5'h04;
    @(negedge clk);
    evt_i = '0; #1;
    chk("R8 irq not yet", {31'd0, irq_o}, 32'd0);
    chk("R2 watermark bit", reg_rdata_o, 32'h04);
    @(negedge clk); #1;
    chk("R8 irq high", {31'd0, irq_o}, 32'd1);
    // masked source does not raise irq
    cyc(7'h00, 1, 5'h04, 32'h04);
    cyc(7'h00, 0, 5'h00, 0);
    cyc(7'h08, 0, 5'h00, 0);
    cyc(7'h00, 0, 5'h00, 0);
    chk("R8 masked irq low", {31'd0, irq_o}, 32'd0);
    cyc(7'h00, 1, 5'h04, 32'h7F);

    // R4 held receive-not-empty and clear in the same cycle
    cyc(7'h10, 0, 5'h00, 0);
    cyc(7'h10, 1, 5'h04, 32'h10);
    rd(5'h04, "R4 set wins", 32'h10);

    // Random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] ev;
      logic [4:0] a;
      int pick;
      ev = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h00;
      pick = $urandom % 6;
      case (pick)
        0: a = 5'h04; 1: a = 5'h08; 2: a = 5'h0C;
        3: a = 5'h10; 4: a = 5'h00; default: a = 5'h14;
      endcase
      cyc(ev, ($urandom % 2) == 1, a, $urandom);
    end
    cyc('0, 0, 5'h00, 0);
    finish_run();
  end

endmodule